// File: doc/BRIEF.md
# Core Module Control Register Bank

This block is the control and status register bank of a processor core module. A host reaches it over a plain 32-bit register bus. The byte offset is decoded as a word index, and address bits 1:0 are ignored. The bank holds the following:

- fixed identification and status words
- two oscillator words that accept writes only while an unlock key sits in the key register
- a control word that drives an LED line, selects memory remap and raises a one-cycle reset request
- two flag words written through separate set and clear addresses
- an SDRAM configuration word and an init word
- a small software interrupt with separate IRQ and FIQ enable masks

Byte offsets 0x100 to 0x1FF form a read-only window onto a presence-detect byte table. The last table entry and the SDRAM size code follow the memory-size input.

Reads are registered. The data returned reflects the state before any write made in the same cycle. An access to an index with no function returns zero, has no effect and raises a one-cycle error strobe.

Top module: `cmr_core_regs`

## Requirements
- R1: Out of reset, index 0 reads 0x411A3001, index 1 reads 0 and index 4 reads 0x00100000. After reset, flash_en_o is 1 and led_o, rst_req_o, irq_o, fiq_o and err_o are 0.
- R2: A write to index 5 stores data bits 15:0. A read of index 5 returns 0x0001A05F when the stored key is 0xA05F, and the stored value otherwise.
- R3: Writes to index 2 (oscillator) and index 7 (auxiliary oscillator) take effect only while the key register holds 0xA05F. At any other time they are dropped.
- R4: A write to index 3 changes only bits 0 and 2. Bit 3 reads back as 0. Writing bit 3 as 1 raises rst_req_o for exactly the one cycle that follows the write edge.
- R5: led_o equals control bit 0, and flash_en_o equals the inverse of control bit 2. Both change only on a write to index 3.
- R6: Index 12 reads the flags word. A write to index 12 ORs the data in, and a write to index 13 clears every bit written as 1. Indices 14 and 15 do the same for a second flags word, which reads at index 14.
- R7: Reset values are: index 2 = 0x01000048, index 7 = 0x0007FEFF, index 9 = 0x00000112, and index 8 = 0x00011122 ORed with a size code taken from mem_mb. The size code is 0x10 for 256 or more, 0x0C for 128 or more, 0x08 for 64 or more, 0x04 for 32 or more, and 0 below 32.
- R8: Reads at byte offsets 0x100 to 0x17F return the table byte selected by (offset-0x100)>>2, zero-extended. Entries 0 to 3 are 0x80, 0x08, 0x04 and 0x0B. Entry 31 is the density byte: 64, 32, 16, 4 or 2 for the same size bands as R7. Offsets 0x180 to 0x1FF read 0.
- R9: The software interrupt level exists only in bit 0. Writing data bit 0 as 1 to index 20 sets it, and to index 21 clears it. Index 20 reads the level. Index 17 reads the raw level, index 18 reads the IRQ enable mask, and index 16 reads level AND mask. Index 18 ORs enable bits in and index 19 clears them.
- R10: Indices 24, 25, 26 and 27 mirror the IRQ registers of R9 for the FIQ mask (status, raw, set, clear). irq_o is 1 exactly when level AND the IRQ mask is non-zero, and fiq_o does the same with the FIQ mask.
- R11: Indices 32 to 35 read 0, and writes to them change nothing and raise no error.
- R12: A read of an index with no read function returns 0, and a write to an index with no write function changes nothing. Either one raises err_o for the one cycle after the access.
- R13: bus_rdata and err_o are valid in the cycle after bus_rd. When a read and a write reach the same index in one cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_mb | input | MB_W | Installed memory size in megabytes, sampled for presets |
| bus_addr | input | AW | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| flash_en_o | output | 1 | Boot flash mapped at address zero |
| led_o | output | 1 | LED drive |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | Masked interrupt, IRQ path |
| fiq_o | output | 1 | Masked interrupt, FIQ path |
| err_o | output | 1 | One-cycle strobe for an access to an unmapped index |

## Verification
A read and a write can land on the same register in one cycle, so the registered read path and the register update collide. The bench drives both strobes together on the init and flags words. It expects the returned data to be the old contents, and a read on the following cycle to show the new contents. A control write that carries both the reset-request bit and the remap bit also makes the pulse and the flash-enable drop fall on the same edge. Both effects are sampled in that one cycle.

// File: rtl/cmr_pkg.sv
package cmr_pkg;
  // Word indices (byte offset >> 2)
  localparam int IX_ID       = 0;
  localparam int IX_PROC     = 1;
  localparam int IX_OSC      = 2;
  localparam int IX_CTRL     = 3;
  localparam int IX_STAT     = 4;
  localparam int IX_LOCK     = 5;
  localparam int IX_AUX      = 7;
  localparam int IX_SDRAM    = 8;
  localparam int IX_INIT     = 9;
  localparam int IX_FLG_SET  = 12;
  localparam int IX_FLG_CLR  = 13;
  localparam int IX_NVF_SET  = 14;
  localparam int IX_NVF_CLR  = 15;
  localparam int IX_IRQ_STAT = 16;
  localparam int IX_IRQ_RAW  = 17;
  localparam int IX_IRQ_SET  = 18;
  localparam int IX_IRQ_CLR  = 19;
  localparam int IX_SW_SET   = 20;
  localparam int IX_SW_CLR   = 21;
  localparam int IX_FIQ_STAT = 24;
  localparam int IX_FIQ_RAW  = 25;
  localparam int IX_FIQ_SET  = 26;
  localparam int IX_FIQ_CLR  = 27;
  localparam int IX_VOLT_LO  = 32;
  localparam int IX_VOLT_HI  = 35;
  localparam int IX_WIN      = 64;

  localparam logic [31:0] ID_WORD    = 32'h411A_3001;
  localparam logic [31:0] STAT_WORD  = 32'h0010_0000;
  localparam logic [15:0] LOCK_KEY   = 16'hA05F;
  localparam logic [31:0] LOCK_OPEN  = 32'h0001_A05F;
  localparam logic [31:0] OSC_RST    = 32'h0100_0048;
  localparam logic [31:0] AUX_RST    = 32'h0007_FEFF;
  localparam logic [31:0] INIT_RST   = 32'h0000_0112;
  localparam logic [31:0] SDRAM_BASE = 32'h0001_1122;

  typedef struct packed {
    logic remap;
    logic led;
  } ctrl_t;
endpackage

// File: rtl/cmr_setclr_reg.sv
module cmr_setclr_reg #(
  parameter int          W       = 32,
  parameter int          IW      = 7,
  parameter int          SET_IX  = 12,
  parameter int          CLR_IX  = 13,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  q
);
  localparam logic [IW-1:0] SET_SEL = IW'(SET_IX);
  localparam logic [IW-1:0] CLR_SEL = IW'(CLR_IX);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_VAL;
    end else if (wr && idx == SET_SEL) begin
      q <= q | wdata;
    end else if (wr && idx == CLR_SEL) begin
      q <= q & ~wdata;
    end
  end
endmodule

// File: rtl/cmr_size_decode.sv
module cmr_size_decode #(
  parameter int MB_W = 12
) (
  input  logic [MB_W-1:0] mem_mb,
  output logic [7:0]      sdram_code,
  output logic [7:0]      density
);
  localparam logic [MB_W-1:0] MB_256 = MB_W'(256);
  localparam logic [MB_W-1:0] MB_128 = MB_W'(128);
  localparam logic [MB_W-1:0] MB_64  = MB_W'(64);
  localparam logic [MB_W-1:0] MB_32  = MB_W'(32);

  always_comb begin
    if (mem_mb >= MB_256) begin
      sdram_code = 8'h10; density = 8'd64;
    end else if (mem_mb >= MB_128) begin
      sdram_code = 8'h0C; density = 8'd32;
    end else if (mem_mb >= MB_64) begin
      sdram_code = 8'h08; density = 8'd16;
    end else if (mem_mb >= MB_32) begin
      sdram_code = 8'h04; density = 8'd4;
    end else begin
      sdram_code = 8'h00; density = 8'd2;
    end
  end
endmodule

// File: rtl/cmr_spd_rom.sv
module cmr_spd_rom #(
  parameter int DEPTH = 32,
  parameter int EW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic [EW-1:0] entry,
  input  logic [7:0]    density,
  output logic [7:0]    byte_q
);
  function automatic logic [7:0] table_byte(input int e, input logic [7:0] dens);
    if (e == DEPTH - 1) return dens;
    case (e)
      0:  return 8'h80;
      1:  return 8'h08;
      2:  return 8'h04;
      3:  return 8'h0B;
      4:  return 8'h09;
      5:  return 8'h01;
      6:  return 8'h40;
      8:  return 8'h02;
      9:  return 8'hA0;
      10: return 8'hA0;
      13: return 8'h08;
      15: return 8'h01;
      16: return 8'h0E;
      17: return 8'h04;
      18: return 8'h1C;
      19: return 8'h01;
      20: return 8'h02;
      21: return 8'h20;
      22: return 8'hC0;
      27: return 8'h30;
      28: return 8'h28;
      29: return 8'h30;
      30: return 8'h28;
      default: return 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (en) byte_q <= table_byte(int'(entry), density);
  end
endmodule

// File: rtl/cmr_irq_unit.sv
module cmr_irq_unit import cmr_pkg::*; #(
  parameter int W  = 32,
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  level,
  output logic [W-1:0]  irq_mask,
  output logic [W-1:0]  fiq_mask,
  output logic          irq_o,
  output logic          fiq_o
);
  localparam logic [IW-1:0] SW_SET_SEL = IW'(IX_SW_SET);
  localparam logic [IW-1:0] SW_CLR_SEL = IW'(IX_SW_CLR);

  logic          soft_q;
  logic [W-1:0]  mask [2];
  logic          line [2];

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_q <= 1'b0;
    end else if (wr && idx == SW_SET_SEL && wdata[0]) begin
      soft_q <= 1'b1;
    end else if (wr && idx == SW_CLR_SEL && wdata[0]) begin
      soft_q <= 1'b0;
    end
  end

  assign level = {{(W-1){1'b0}}, soft_q};

  for (genvar c = 0; c < 2; c++) begin : g_path
    localparam int SETI = (c == 0) ? IX_IRQ_SET : IX_FIQ_SET;
    localparam int CLRI = (c == 0) ? IX_IRQ_CLR : IX_FIQ_CLR;
    cmr_setclr_reg #(
      .W(W), .IW(IW), .SET_IX(SETI), .CLR_IX(CLRI), .RST_VAL('0)
    ) u_mask (
      .clk(clk), .rst(rst), .wr(wr), .idx(idx), .wdata(wdata), .q(mask[c])
    );
    assign line[c] = |(level & mask[c]);
  end

  assign irq_mask = mask[0];
  assign fiq_mask = mask[1];
  assign irq_o    = line[0];
  assign fiq_o    = line[1];
endmodule

// File: rtl/cmr_core_regs.sv
module cmr_core_regs import cmr_pkg::*; #(
  parameter int AW        = 9,
  parameter int MB_W      = 12,
  parameter int SPD_DEPTH = 32,
  parameter int IRQ_W     = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [MB_W-1:0] mem_mb,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            flash_en_o,
  output logic            led_o,
  output logic            rst_req_o,
  output logic            irq_o,
  output logic            fiq_o,
  output logic            err_o
);
  localparam int IDX_W  = AW - 2;
  localparam int SPD_AW = $clog2(SPD_DEPTH);

  logic [IDX_W-1:0] idx;
  int               ix;
  logic             unused_lsb;

  assign idx        = bus_addr[AW-1:2];
  assign ix         = int'(idx);
  assign unused_lsb = ^bus_addr[1:0];

  logic [31:0] osc_q, aux_q, sdram_q, init_q, rdata_q;
  logic [15:0] lock_q;
  ctrl_t       ctrl_q;
  logic        rst_req_q, err_q, win_q, win_zero_q;
  logic        unlocked;

  assign unlocked = (lock_q == LOCK_KEY);

  // Memory-size presets
  logic [7:0] sdram_code, density;
  cmr_size_decode #(.MB_W(MB_W)) u_size (
    .mem_mb(mem_mb), .sdram_code(sdram_code), .density(density)
  );

  // Set/clear flag words
  logic [31:0] flg_q, nvf_q;
  cmr_setclr_reg #(
    .W(32), .IW(IDX_W), .SET_IX(IX_FLG_SET), .CLR_IX(IX_FLG_CLR), .RST_VAL('0)
  ) u_flags (
    .clk(clk), .rst(rst), .wr(bus_wr), .idx(idx), .wdata(bus_wdata), .q(flg_q)
  );
  cmr_setclr_reg #(
    .W(32), .IW(IDX_W), .SET_IX(IX_NVF_SET), .CLR_IX(IX_NVF_CLR), .RST_VAL('0)
  ) u_nvflags (
    .clk(clk), .rst(rst), .wr(bus_wr), .idx(idx), .wdata(bus_wdata), .q(nvf_q)
  );

  // Local interrupt section
  logic [IRQ_W-1:0] level, irq_mask, fiq_mask;
  cmr_irq_unit #(.W(IRQ_W), .IW(IDX_W)) u_irq (
    .clk(clk), .rst(rst), .wr(bus_wr), .idx(idx), .wdata(bus_wdata[IRQ_W-1:0]),
    .level(level), .irq_mask(irq_mask), .fiq_mask(fiq_mask),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // Presence-detect window
  logic              in_win, spd_hit;
  logic [SPD_AW-1:0] spd_entry;
  logic [7:0]        spd_byte;

  assign in_win    = (ix >= IX_WIN);
  assign spd_hit   = in_win && (ix < IX_WIN + SPD_DEPTH);
  assign spd_entry = SPD_AW'(ix - IX_WIN);

  cmr_spd_rom #(.DEPTH(SPD_DEPTH), .EW(SPD_AW)) u_spd (
    .clk(clk), .en(bus_rd && spd_hit), .entry(spd_entry),
    .density(density), .byte_q(spd_byte)
  );

  // Read decode (pre-write state)
  logic [31:0] rd_val;
  logic        rd_ok;

  always_comb begin
    rd_val = '0;
    rd_ok  = 1'b1;
    case (ix)
      IX_ID:       rd_val = ID_WORD;
      IX_PROC:     rd_val = '0;
      IX_OSC:      rd_val = osc_q;
      IX_CTRL:     rd_val = {29'b0, ctrl_q.remap, 1'b0, ctrl_q.led};
      IX_STAT:     rd_val = STAT_WORD;
      IX_LOCK:     rd_val = unlocked ? LOCK_OPEN : {16'b0, lock_q};
      IX_AUX:      rd_val = aux_q;
      IX_SDRAM:    rd_val = sdram_q;
      IX_INIT:     rd_val = init_q;
      IX_FLG_SET:  rd_val = flg_q;
      IX_NVF_SET:  rd_val = nvf_q;
      IX_IRQ_STAT: rd_val = 32'(level & irq_mask);
      IX_IRQ_RAW:  rd_val = 32'(level);
      IX_IRQ_SET:  rd_val = 32'(irq_mask);
      IX_SW_SET:   rd_val = {31'b0, level[0]};
      IX_FIQ_STAT: rd_val = 32'(level & fiq_mask);
      IX_FIQ_RAW:  rd_val = 32'(level);
      IX_FIQ_SET:  rd_val = 32'(fiq_mask);
      default: begin
        rd_ok = in_win || (ix >= IX_VOLT_LO && ix <= IX_VOLT_HI);
      end
    endcase
  end

  // Write decode
  logic wr_ok;

  always_comb begin
    case (ix)
      IX_OSC, IX_CTRL, IX_LOCK, IX_AUX, IX_SDRAM, IX_INIT,
      IX_FLG_SET, IX_FLG_CLR, IX_NVF_SET, IX_NVF_CLR,
      IX_IRQ_SET, IX_IRQ_CLR, IX_SW_SET, IX_SW_CLR,
      IX_FIQ_SET, IX_FIQ_CLR: wr_ok = 1'b1;
      default: wr_ok = (ix >= IX_VOLT_LO && ix <= IX_VOLT_HI);
    endcase
  end

  // Register state
  always_ff @(posedge clk) begin
    if (rst) begin
      osc_q      <= OSC_RST;
      aux_q      <= AUX_RST;
      init_q     <= INIT_RST;
      sdram_q    <= SDRAM_BASE | {24'b0, sdram_code};
      lock_q     <= '0;
      ctrl_q     <= '0;
      rst_req_q  <= 1'b0;
      err_q      <= 1'b0;
      rdata_q    <= '0;
      win_q      <= 1'b0;
      win_zero_q <= 1'b0;
    end else begin
      rst_req_q <= bus_wr && (ix == IX_CTRL) && bus_wdata[3];
      err_q     <= (bus_rd && !rd_ok) || (bus_wr && !wr_ok);
      if (bus_rd) begin
        rdata_q    <= rd_val;
        win_q      <= in_win;
        win_zero_q <= in_win && !spd_hit;
      end
      if (bus_wr) begin
        case (ix)
          IX_OSC:   if (unlocked) osc_q <= bus_wdata;
          IX_AUX:   if (unlocked) aux_q <= bus_wdata;
          IX_LOCK:  lock_q <= bus_wdata[15:0];
          IX_CTRL:  ctrl_q <= '{remap: bus_wdata[2], led: bus_wdata[0]};
          IX_SDRAM: sdram_q <= bus_wdata;
          IX_INIT:  init_q <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  assign bus_rdata  = win_q ? (win_zero_q ? 32'b0 : {24'b0, spd_byte}) : rdata_q;
  assign flash_en_o = ~ctrl_q.remap;
  assign led_o      = ctrl_q.led;
  assign rst_req_o  = rst_req_q;
  assign err_o      = err_q;
endmodule

// File: rtl/cmr_core_regs_chk.sv
module cmr_core_regs_chk import cmr_pkg::*; #(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [31:0]   bus_wdata,
  input logic          flash_en_o,
  input logic          led_o,
  input logic          rst_req_o,
  input logic          irq_o,
  input logic          fiq_o,
  input logic          err_o,
  input logic [31:0]   osc_q,
  input logic [31:0]   aux_q,
  input logic [15:0]   lock_q
);
  int   widx;
  logic ctrl_wr, unused_chk;

  assign widx       = int'(bus_addr[AW-1:2]);
  assign ctrl_wr    = bus_wr && (widx == IX_CTRL);
  assign unused_chk = ^{bus_addr[1:0], bus_wdata[31:4], bus_wdata[2:0]};

  assert_rst_req_cause_R4: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> $past(ctrl_wr && bus_wdata[3]));

  assert_flash_moves_on_ctrl_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(flash_en_o) |-> $past(ctrl_wr));

  assert_led_moves_on_ctrl_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(led_o) |-> $past(ctrl_wr));

  assert_osc_keyed_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(osc_q) |-> $past(bus_wr && widx == IX_OSC && lock_q == LOCK_KEY));

  assert_aux_keyed_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(aux_q) |-> $past(bus_wr && widx == IX_AUX && lock_q == LOCK_KEY));

  assert_err_cause_R12: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(bus_wr || bus_rd));

  assert_irq_moves_on_write_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(irq_o) |-> $past(bus_wr));

  assert_fiq_moves_on_write_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(fiq_o) |-> $past(bus_wr));
endmodule

bind cmr_core_regs cmr_core_regs_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .flash_en_o(flash_en_o), .led_o(led_o),
  .rst_req_o(rst_req_o), .irq_o(irq_o), .fiq_o(fiq_o), .err_o(err_o),
  .osc_q(osc_q), .aux_q(aux_q), .lock_q(lock_q)
);

// File: tb/cmr_core_regs_bench.sv
module cmr_core_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 9;
  localparam int MB_W = 12;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [MB_W-1:0] mem_mb = MB_W'(128);
  logic [AW-1:0]   bus_addr = '0;
  logic            bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            flash_en_o, led_o, rst_req_o, irq_o, fiq_o, err_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmr_core_regs #(.AW(AW), .MB_W(MB_W)) u_cmr_core_regs (
    .clk(clk), .rst(rst), .mem_mb(mem_mb), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flash_en_o(flash_en_o), .led_o(led_o), .rst_req_o(rst_req_o),
    .irq_o(irq_o), .fiq_o(fiq_o), .err_o(err_o)
  );

  int checks = 0, errors = 0;

  // Bench model
  logic [31:0] m_osc, m_aux, m_sdram, m_init, m_flg, m_nvf, m_ien, m_fen;
  logic [15:0] m_lock;
  logic        m_led, m_remap, m_soft;
  int          m_mb;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] size_code(input int mb);
    if (mb >= 256) return 8'h10;
    if (mb >= 128) return 8'h0C;
    if (mb >= 64)  return 8'h08;
    if (mb >= 32)  return 8'h04;
    return 8'h00;
  endfunction

  function automatic logic [7:0] dens(input int mb);
    if (mb >= 256) return 8'd64;
    if (mb >= 128) return 8'd32;
    if (mb >= 64)  return 8'd16;
    if (mb >= 32)  return 8'd4;
    return 8'd2;
  endfunction

  function automatic bit rd_mapped(input int ix);
    case (ix)
      0,1,2,3,4,5,7,8,9,12,14,16,17,18,20,24,25,26: return 1;
      default: return (ix >= 64) || (ix >= 32 && ix <= 35);
    endcase
  endfunction

  function automatic bit wr_mapped(input int ix);
    case (ix)
      2,3,5,7,8,9,12,13,14,15,18,19,20,21,26,27: return 1;
      default: return (ix >= 32 && ix <= 35);
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input int ix);
    case (ix)
      0:  return 32'h411A3001;
      2:  return m_osc;
      3:  return {29'b0, m_remap, 1'b0, m_led};
      4:  return 32'h00100000;
      5:  return (m_lock == 16'hA05F) ? 32'h0001A05F : {16'b0, m_lock};
      7:  return m_aux;
      8:  return m_sdram;
      9:  return m_init;
      12: return m_flg;
      14: return m_nvf;
      16: return {31'b0, m_soft & m_ien[0]};
      17, 25: return {31'b0, m_soft};
      18: return m_ien;
      20: return {31'b0, m_soft};
      24: return {31'b0, m_soft & m_fen[0]};
      26: return m_fen;
      64: return 32'h80;
      65: return 32'h08;
      66: return 32'h04;
      67: return 32'h0B;
      95: return {24'b0, dens(m_mb)};
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_write(input int ix, input logic [31:0] d);
    case (ix)
      2:  if (m_lock == 16'hA05F) m_osc = d;
      3:  begin m_led = d[0]; m_remap = d[2]; end
      5:  m_lock = d[15:0];
      7:  if (m_lock == 16'hA05F) m_aux = d;
      8:  m_sdram = d;
      9:  m_init = d;
      12: m_flg = m_flg | d;
      13: m_flg = m_flg & ~d;
      14: m_nvf = m_nvf | d;
      15: m_nvf = m_nvf & ~d;
      18: m_ien = m_ien | d;
      19: m_ien = m_ien & ~d;
      20: if (d[0]) m_soft = 1'b1;
      21: if (d[0]) m_soft = 1'b0;
      26: m_fen = m_fen | d;
      27: m_fen = m_fen & ~d;
      default: ;
    endcase
  endtask

  task automatic do_reset(input int mb);
    @(negedge clk);
    mem_mb = MB_W'(mb);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_mb = mb; m_osc = 32'h01000048; m_aux = 32'h0007FEFF; m_init = 32'h00000112;
    m_sdram = 32'h00011122 | {24'b0, size_code(mb)};
    m_lock = '0; m_led = 0; m_remap = 0; m_soft = 0;
    m_flg = '0; m_nvf = '0; m_ien = '0; m_fen = '0;
  endtask

  task automatic check_pins(input string req);
    chk({req, " flash_en"}, {31'b0, flash_en_o}, {31'b0, ~m_remap});
    chk({req, " led"},      {31'b0, led_o},      {31'b0, m_led});
    chk({req, " irq"},      {31'b0, irq_o},      {31'b0, m_soft & m_ien[0]});
    chk({req, " fiq"},      {31'b0, fiq_o},      {31'b0, m_soft & m_fen[0]});
  endtask

  task automatic wr_chk(input int ix, input logic [31:0] d, input string req);
    @(negedge clk);
    bus_addr = AW'(ix * 4); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    m_write(ix, d);
    chk({req, " R12 wr err"}, {31'b0, err_o}, {31'b0, !wr_mapped(ix)});
    chk({req, " R4 rst_req"}, {31'b0, rst_req_o}, {31'b0, (ix == 3) && d[3]});
    check_pins(req);
  endtask

  task automatic rd_chk(input int ix, input string req);
    logic [31:0] e;
    e = exp_read(ix);
    @(negedge clk);
    bus_addr = AW'(ix * 4); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk({req, " R13 rdata"}, bus_rdata, e);
    chk({req, " R12 rd err"}, {31'b0, err_o}, {31'b0, !rd_mapped(ix)});
  endtask

  task automatic rdwr_chk(input int ix, input logic [31:0] d, input string req);
    logic [31:0] e;
    e = exp_read(ix);
    @(negedge clk);
    bus_addr = AW'(ix * 4); bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    m_write(ix, d);
    chk({req, " R13 old value"}, bus_rdata, e);
    rd_chk(ix, {req, " R13 new value"});
  endtask

  localparam int POOL_N = 38;
  int pool [POOL_N] = '{0,1,2,3,4,5,6,7,8,9,10,11,12,13,14,15,16,17,18,19,
                        20,21,22,24,25,26,27,32,35,36,40,64,65,66,67,95,100,127};

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20517));
    do_reset(128);
    // R1 reset state and constants
    chk("R1 flash_en", {31'b0, flash_en_o}, 32'h1);
    chk("R1 led",      {31'b0, led_o}, 32'h0);
    chk("R1 rst_req",  {31'b0, rst_req_o}, 32'h0);
    chk("R1 irq/fiq",  {30'b0, irq_o, fiq_o}, 32'h0);
    chk("R1 err",      {31'b0, err_o}, 32'h0);
    rd_chk(0, "R1 id"); rd_chk(1, "R1 proc"); rd_chk(4, "R1 status");
    // R7 reset values
    rd_chk(2, "R7 osc"); rd_chk(7, "R7 aux"); rd_chk(9, "R7 init"); rd_chk(8, "R7 sdram");
    chk("R7 sdram 128MB", exp_read(8), 32'h0001112E);
    // R2 / R3 key handling
    wr_chk(2, 32'hDEAD0001, "R3 locked osc"); rd_chk(2, "R3 osc kept");
    wr_chk(5, 32'h1234A05F, "R2 key"); rd_chk(5, "R2 open readback");
    wr_chk(2, 32'h0BAD0002, "R3 open osc"); rd_chk(2, "R3 osc new");
    wr_chk(7, 32'h00C0FFEE, "R3 open aux"); rd_chk(7, "R3 aux new");
    wr_chk(5, 32'h00000005, "R2 relock"); rd_chk(5, "R2 plain readback");
    wr_chk(7, 32'h11111111, "R3 locked aux"); rd_chk(7, "R3 aux kept");
    // R4 / R5 control, pulse and remap on the same edge
    wr_chk(3, 32'h0000000F, "R4 R5 ctrl all"); rd_chk(3, "R4 ctrl readback");
    chk("R4 rst_req value", exp_read(3), 32'h5);
    wr_chk(3, 32'h00000008, "R4 ctrl pulse only");
    @(negedge clk);
    chk("R4 pulse one cycle", {31'b0, rst_req_o}, 32'h0);
    wr_chk(3, 32'h00000004, "R5 remap");
    // R6 flags
    wr_chk(12, 32'h0000F00F, "R6 flg set"); wr_chk(13, 32'h00000003, "R6 flg clr");
    rd_chk(12, "R6 flags"); chk("R6 flags value", exp_read(12), 32'h0000F00C);
    wr_chk(14, 32'h80000001, "R6 nv set"); wr_chk(15, 32'h00000001, "R6 nv clr");
    rd_chk(14, "R6 nvflags");
    // R9 / R10 interrupt section
    wr_chk(20, 32'h00000001, "R9 soft set"); rd_chk(17, "R9 raw");
    rd_chk(16, "R9 stat masked off");
    wr_chk(18, 32'h00000003, "R10 irq en"); rd_chk(16, "R9 stat");
    chk("R10 irq high", {31'b0, irq_o}, 32'h1);
    wr_chk(26, 32'h00000001, "R10 fiq en"); rd_chk(24, "R10 fiq stat");
    wr_chk(19, 32'h00000001, "R9 irq clr"); rd_chk(18, "R9 irq mask");
    wr_chk(21, 32'h00000001, "R9 soft clr"); rd_chk(20, "R9 soft read");
    wr_chk(27, 32'h00000001, "R10 fiq clr"); rd_chk(26, "R10 fiq mask");
    // R11 voltage, R12 unmapped
    wr_chk(33, 32'hFFFFFFFF, "R11 volt wr"); rd_chk(33, "R11 volt rd");
    rd_chk(6, "R12 unmapped 6"); rd_chk(10, "R12 unmapped 10"); rd_chk(13, "R12 wo read");
    wr_chk(0, 32'h0, "R12 wr ro"); rd_chk(0, "R12 id kept");
    wr_chk(64, 32'h0, "R12 wr window"); rd_chk(64, "R8 entry0");
    // R13 read and write in one cycle
    rdwr_chk(9, 32'hA5A5A5A5, "R13 init");
    rdwr_chk(12, 32'h00000F00, "R13 flags");
    // R7 / R8 size bands
    do_reset(16);  rd_chk(8, "R7 sdram 16");  rd_chk(95, "R8 dens 16");
    do_reset(32);  rd_chk(8, "R7 sdram 32");  rd_chk(95, "R8 dens 32");
    do_reset(64);  rd_chk(8, "R7 sdram 64");  rd_chk(95, "R8 dens 64");
    do_reset(255); rd_chk(8, "R7 sdram 255"); rd_chk(95, "R8 dens 255");
    do_reset(300); rd_chk(8, "R7 sdram 300"); rd_chk(95, "R8 dens 300");
    rd_chk(65, "R8 entry1"); rd_chk(66, "R8 entry2"); rd_chk(67, "R8 entry3");
    rd_chk(96, "R8 high zero"); rd_chk(127, "R8 top zero");
    // Random mix
    do_reset(128);
    for (int n = 0; n < 800; n++) begin
      int ix;
      logic [31:0] d;
      ix = pool[$urandom_range(POOL_N - 1, 0)];
      d  = $urandom();
      if (ix == 5 && $urandom_range(1, 0) == 1) d[15:0] = 16'hA05F;
      case ($urandom_range(2, 0))
        0: wr_chk(ix, d, "RND R6 R9");
        1: rd_chk(ix, "RND R8 R10");
        default: rdwr_chk(ix, d, "RND R13");
      endcase
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule